// File: doc/BRIEF.md
# Flash Lock-Bit Protection Controller

This block stands between a programming command port and a 2K-byte flash program memory model. It holds two sticky protection bits, here called the write lock and the read lock. For each single-cycle command strobe it decides whether the command is carried out. The commands are byte program, byte verify (read), lock program and chip erase. The response (read data, read-valid and a reject flag) appears one clock after the strobe. A two-bit mode output always shows the protection level in force.

Protection is graded. Setting the write lock stops further byte programming. Setting both locks also stops verify, which then returns 00h. The locks cannot be cleared one at a time. Only chip erase clears them, and it sets every byte to FFh in the same cycle. Chip erase is always accepted. Synchronous reset puts the model in its blank state: locks cleared and all bytes FFh.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, mode is 0, reject and rd_valid are low, and every address reads FFh.
- R2: mode encodes protection: 0 when the write lock is clear, 2 when only the write lock is set, 3 when both locks are set. The value 1 never appears.
- R3: In mode 0, byte program (cmd_op=1) at an in-range address stores cmd_data. A later verify (cmd_op=2) of that address returns it.
- R4: In modes 2 and 3, byte program is refused with a reject pulse and leaves the array unchanged. In mode 2, verify still returns array data.
- R5: In mode 3, verify is refused. rd_valid pulses with rd_data=00h and reject high.
- R6: Lock program (cmd_op=3) sets the write lock when cmd_data[0]=1 and the read lock when cmd_data[1]=1. A zero bit leaves that lock as it was, so no command except erase clears a lock.
- R7: With only the read lock set, the block behaves as unprotected (mode 0; program and verify execute).
- R8: Chip erase (cmd_op=4) is always accepted without reject. It clears both locks and makes every byte read FFh.
- R9: A program or verify whose address is above 7FFh is refused with a reject pulse and does not change the array. Such a verify returns 00h.
- R10: rd_valid and reject are registered one-cycle pulses in the cycle after the strobe. Neither rises without a strobe.
- R11: A strobe with an undefined cmd_op (5, 6, 7) is rejected and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to blank state |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 3 | 0 idle, 1 program, 2 verify, 3 lock, 4 erase |
| cmd_addr | input | 12 | Byte address |
| cmd_data | input | 8 | Program data or lock-select bits |
| rd_valid | output | 1 | Verify response present |
| rd_data | output | 8 | Verify data (00h when refused) |
| reject | output | 1 | Command refused |
| mode | output | 2 | Protection mode 0, 2 or 3 |

## Verification
The assertions check on every cycle the properties that depend only on ports across one edge. These are the mode encoding and the stickiness of the locks, erase always clearing the mode without reject, and refusal of a program in a locked mode. They also cover a verify returning 00h when fully locked or out of range, and the absence of pulses without a strobe. That stored data survives a refused program, that erase really restores FFh everywhere, and that a read-lock-only device acts as open can only be shown by the bench's scenarios. The bench compares the outputs against its behavioural memory model.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_READ  = 3'd2,
        OP_LOCK  = 3'd3,
        OP_ERASE = 3'd4
    } flash_op_e;

    localparam logic [1:0] MODE_OPEN  = 2'd0;
    localparam logic [1:0] MODE_WLOCK = 2'd2;
    localparam logic [1:0] MODE_FULL  = 2'd3;

    typedef struct packed {
        logic do_write;
        logic do_read;
        logic mask_read;
        logic do_lock;
        logic do_erase;
        logic refuse;
    } verdict_t;

    function automatic logic [1:0] lock_mode(input logic wlock, input logic rlock);
        if (!wlock)
            return MODE_OPEN;
        else if (rlock)
            return MODE_FULL;
        else
            return MODE_WLOCK;
    endfunction

endpackage

// File: rtl/flash_lock_bits.sv
module flash_lock_bits (
    input  logic clk,
    input  logic rst,
    input  logic set_wlock,
    input  logic set_rlock,
    input  logic erase,
    output logic wlock,
    output logic rlock
);
    always_ff @(posedge clk) begin
        if (rst || erase) begin
            wlock <= 1'b0;
            rlock <= 1'b0;
        end else begin
            if (set_wlock) wlock <= 1'b1;
            if (set_rlock) rlock <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2048
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wlock,
    input  logic              rlock,
    output verdict_t          verdict
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic in_range;
    assign in_range = ({1'b0, cmd_addr} < LIMIT);

    always_comb begin
        verdict = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_IDLE: ;
                OP_PROG: begin
                    if (in_range && !wlock) verdict.do_write = 1'b1;
                    else                    verdict.refuse   = 1'b1;
                end
                OP_READ: begin
                    verdict.do_read = 1'b1;
                    if (!in_range || (wlock && rlock)) begin
                        verdict.mask_read = 1'b1;
                        verdict.refuse    = 1'b1;
                    end
                end
                OP_LOCK:  verdict.do_lock  = 1'b1;
                OP_ERASE: verdict.do_erase = 1'b1;
                default:  verdict.refuse   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              erase,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DEPTH-1:0]  written;

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            written <= '0;
        end else if (wr_en) begin
            written[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst && !erase)
            cells[idx] <= wdata;
    end

    assign rdata = written[idx] ? cells[idx] : {DATA_W{1'b1}};
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              reject,
    output logic [1:0]        mode
);
    localparam int IDX_W = $clog2(DEPTH);

    verdict_t          verdict;
    logic              wlock, rlock;
    logic [DATA_W-1:0] arr_rdata;
    logic [IDX_W-1:0]  idx;

    assign idx = cmd_addr[IDX_W-1:0];

    flash_cmd_gate #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_gate (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .wlock     (wlock),
        .rlock     (rlock),
        .verdict   (verdict)
    );

    flash_lock_bits u_locks (
        .clk       (clk),
        .rst       (rst),
        .set_wlock (verdict.do_lock & cmd_data[0]),
        .set_rlock (verdict.do_lock & cmd_data[1]),
        .erase     (verdict.do_erase),
        .wlock     (wlock),
        .rlock     (rlock)
    );

    flash_byte_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .wr_en (verdict.do_write),
        .erase (verdict.do_erase),
        .idx   (idx),
        .wdata (cmd_data),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            reject   <= 1'b0;
        end else begin
            rd_valid <= verdict.do_read;
            reject   <= verdict.refuse;
            if (verdict.do_read)
                rd_data <= verdict.mask_read ? '0 : arr_rdata;
        end
    end

    assign mode = lock_mode(wlock, rlock);
endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              reject,
    input logic [1:0]        mode
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    assert_mode_code_R2: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd1);

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && !(cmd_valid && cmd_op == OP_ERASE)) |=> mode[1]);

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FULL && !(cmd_valid && cmd_op == OP_ERASE)) |=> mode == MODE_FULL);

    assert_erase_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ERASE) |=> (mode == MODE_OPEN && !reject));

    assert_prog_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROG && mode != MODE_OPEN) |=> reject);

    assert_read_full_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ && mode == MODE_FULL)
        |=> (rd_valid && reject && rd_data == '0));

    assert_read_range_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ && {1'b0, cmd_addr} >= LIMIT)
        |=> (rd_valid && reject && rd_data == '0));

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!reject && !rd_valid));
endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
) chk (.*);

// File: tb/flash_lock_ctrl_test.sv
`timescale 1ns/1ps
module flash_lock_ctrl_test;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 2048;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [11:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        reject;
    logic [1:0]  mode;

    always #2.5 clk = ~clk;

    flash_lock_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .reject(reject), .mode(mode)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] ref_mem [DEPTH];
    bit ref_w, ref_r;
    bit exp_rv, exp_rej;
    logic [7:0] exp_rd;
    string exp_tag;

    function automatic logic [1:0] ref_mode();
        if (!ref_w) return 2'd0;
        return ref_r ? 2'd3 : 2'd2;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(exp_tag, "mode", int'(mode), int'(ref_mode()));
        check(exp_tag, "reject", int'(reject), int'(exp_rej));
        check(exp_tag, "rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv) check(exp_tag, "rd_data", int'(rd_data), int'(exp_rd));
    endtask

    task automatic model(bit v, int op, int addr, int data);
        bit inr;
        inr = (addr < DEPTH);
        exp_rv = 0; exp_rej = 0;
        if (!v) return;
        case (op)
            0: ;
            1: if (!inr || ref_w) exp_rej = 1; else ref_mem[addr] = 8'(data);
            2: begin
                exp_rv = 1;
                if (!inr || (ref_w && ref_r)) begin exp_rej = 1; exp_rd = 8'h00; end
                else exp_rd = ref_mem[addr];
            end
            3: begin
                if (data[0]) ref_w = 1;
                if (data[1]) ref_r = 1;
            end
            4: begin
                for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
                ref_w = 0; ref_r = 0;
            end
            default: exp_rej = 1;
        endcase
    endtask

    task automatic step(string tag, bit v, int op, int addr, int data);
        @(negedge clk);
        compare();
        cmd_valid = v;
        cmd_op    = 3'(op);
        cmd_addr  = 12'(addr);
        cmd_data  = 8'(data);
        model(v, op, addr, data);
        exp_tag = tag;
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0);
    endtask

    initial begin
        #500us;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        ref_w = 0; ref_r = 0; exp_rv = 0; exp_rej = 0; exp_rd = 0;
        exp_tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: blank state after reset
        idle("R1");
        step("R1", 1, 2, 12'h000, 0);
        step("R1", 1, 2, 12'h7FF, 0);
        step("R1", 1, 2, 12'h3A5, 0);
        // R3: program and read back in open mode
        step("R3", 1, 1, 12'h010, 8'h5A);
        step("R3", 1, 1, 12'h7FF, 8'hC3);
        step("R3", 1, 1, 12'h000, 8'h00);
        step("R3", 1, 2, 12'h010, 0);
        step("R3", 1, 2, 12'h7FF, 0);
        step("R3", 1, 2, 12'h000, 0);
        step("R3", 1, 1, 12'h010, 8'hA7);
        step("R3", 1, 2, 12'h010, 0);
        // R9: out-of-range commands
        step("R9", 1, 1, 12'h800, 8'h11);
        step("R9", 1, 2, 12'h800, 0);
        step("R9", 1, 1, 12'hFFF, 8'h22);
        step("R9", 1, 2, 12'h000, 0);
        // R11: undefined opcodes
        step("R11", 1, 5, 12'h010, 8'h03);
        step("R11", 1, 6, 12'h010, 8'h03);
        step("R11", 1, 7, 12'h010, 8'h03);
        step("R11", 1, 2, 12'h010, 0);
        // R10: no pulses without a strobe
        idle("R10");
        step("R10", 0, 2, 12'h010, 0);
        step("R10", 0, 1, 12'h010, 8'h99);
        step("R10", 1, 2, 12'h010, 0);
        // R6 / R7: lock with zero bits, then read lock only
        step("R6", 1, 3, 0, 8'h00);
        step("R7", 1, 3, 0, 8'h02);
        step("R7", 1, 1, 12'h020, 8'h3C);
        step("R7", 1, 2, 12'h020, 0);
        // R2 / R5: add write lock -> fully locked
        step("R2", 1, 3, 0, 8'h01);
        step("R5", 1, 2, 12'h010, 0);
        step("R5", 1, 2, 12'h020, 0);
        step("R4", 1, 1, 12'h030, 8'h77);
        step("R6", 1, 3, 0, 8'h00);
        idle("R6");
        // R8: erase clears everything
        step("R8", 1, 4, 12'h123, 8'h00);
        step("R8", 1, 2, 12'h010, 0);
        step("R8", 1, 2, 12'h020, 0);
        step("R8", 1, 2, 12'h7FF, 0);
        // R4: write lock only -> program refused, read allowed
        step("R3", 1, 1, 12'h040, 8'h81);
        step("R2", 1, 3, 0, 8'h01);
        step("R4", 1, 1, 12'h040, 8'h18);
        step("R4", 1, 1, 12'h041, 8'h18);
        step("R4", 1, 2, 12'h040, 0);
        step("R4", 1, 2, 12'h041, 0);
        step("R9", 1, 2, 12'h900, 0);
        // R8: erase accepted in mode 2 too
        step("R8", 1, 4, 0, 0);
        step("R8", 1, 2, 12'h040, 0);
        idle("R8");
        idle("R8");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule